// File: doc/BRIEF.md
# Data Cache Tag State Checker

This block examines a single data-cache tag as it is read out of the tag array. The tag arrives as a 32-bit high word and a 64-bit low word, together with the 13-bit line index that was used to read it. The block sorts the 5-bit coherence code into one of five legal line states. It flags an illegal code as a tag-state error. For a legal line it checks the two parity bits that cover the physical tag. From the same inputs it rebuilds the line's physical address, unpacks the replacement order of the four ways, and splits the index into its bank and set.

One tag is accepted on each cycle in which the strobe is high. Every result is registered, and a one-cycle valid pulse marks the cycle in which the results appear, one clock after the strobe. Between strobes the result registers keep their last values. Error-handling firmware or a scrub engine can use the flags and the decoded fields directly, without unpacking the raw words.

Top module: `dctag_checker`

## Requirements
- R1: A strobe in cycle N causes `out_valid` to be high in cycle N+1. `out_valid` is low one cycle after any cycle with no strobe.
- R2: The state code is `tag_hi[29:25]`. The codes map onto `out_state` as follows: 0x0F→1 (coherent shared), 0x13→2 (non-coherent exclusive clean), 0x19→3 (non-coherent exclusive dirty), 0x16→4 (coherent exclusive clean) and 0x1C→5 (coherent exclusive dirty). For each of these, `out_state_err` is 0.
- R3: Code 0x00 gives `out_state`=0 (invalid). Every other code outside the five in R2 gives `out_state`=7 (illegal). Both of these cases set `out_state_err`=1.
- R4: For a legal state, `out_addr_err` is 1 exactly when either of two parity checks fails. The first check compares `tag_lo[11]` with the XOR of `tag_lo[39:26]`. The second compares `tag_lo[10]` with the XOR of `tag_lo[25:13]`.
- R5: When the state is not legal, `out_addr_err` is 0, whatever the parity bits are.
- R6: `out_paddr` equals `{tag_lo[39:13], line_idx[12:0]}`.
- R7: The replacement field is `tag_hi[21:14]`. `out_lru_order` holds four 2-bit way numbers, with bits 1:0 the least recently used way and bits 7:6 the most recently used.
- R8: `out_bank` equals `{line_idx[12], line_idx[5]}`, and `out_set` equals `line_idx[11:6]`.
- R9: A synchronous reset clears `out_valid`, `out_state_err` and `out_addr_err`. In a cycle with no strobe, all result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_strobe | input | 1 | Accepts the tag presented this cycle |
| tag_hi | input | 32 | Tag high word (state and replacement fields) |
| tag_lo | input | 64 | Tag low word (physical tag and parity bits) |
| line_idx | input | 13 | Line index used for the tag read |
| out_valid | output | 1 | One-cycle pulse marking new results |
| out_state | output | 3 | Decoded line state (encoding per R2/R3) |
| out_state_err | output | 1 | State code is not one of the five legal codes |
| out_addr_err | output | 1 | Physical-tag parity mismatch on a legal line |
| out_paddr | output | 40 | Reconstructed physical address |
| out_lru_order | output | 8 | Four 2-bit way numbers, LRU in bits 1:0 |
| out_bank | output | 2 | Bank selected by the index |
| out_set | output | 6 | Set selected by the index |

## Verification
Several properties are checked by assertions on every cycle:
- the valid pulse follows the strobe exactly;
- results hold steady between strobes;
- a state error never appears together with an address error;
- the state error agrees with the decoded state;
- the low address bits follow the index;
- the bank and set bits track the index.

Some behaviour can only be shown by the bench scenarios, which compare against independently computed values:
- that each of the five legal codes maps to the right state number;
- that each of the two parity ranges is covered correctly;
- that the replacement order is unpacked in the right direction;
- that reset clears the flags.

// File: rtl/dctag_pkg.sv
package dctag_pkg;
  localparam int TAG_HI_W  = 32;
  localparam int TAG_LO_W  = 64;
  localparam int IDX_W     = 13;
  localparam int PA_W      = 40;
  localparam int WAYS      = 4;
  localparam int WAY_W     = $clog2(WAYS);
  localparam int LRU_W     = WAYS * WAY_W;

  localparam int ST_LSB    = 25;
  localparam int ST_W      = 5;
  localparam int LRU_LSB   = 14;

  localparam int PT1_HI    = 39;
  localparam int PT1_LO    = 26;
  localparam int PT1_CHK   = 11;
  localparam int PT0_HI    = 25;
  localparam int PT0_LO    = 13;
  localparam int PT0_CHK   = 10;

  typedef enum logic [2:0] {
    LS_INVALID     = 3'd0,
    LS_COH_SHARED  = 3'd1,
    LS_NC_EX_CLEAN = 3'd2,
    LS_NC_EX_DIRTY = 3'd3,
    LS_CO_EX_CLEAN = 3'd4,
    LS_CO_EX_DIRTY = 3'd5,
    LS_ILLEGAL     = 3'd7
  } line_state_e;
endpackage

// File: rtl/dctag_state_decode.sv
module dctag_state_decode
  import dctag_pkg::*;
#(
  parameter int CODE_W = ST_W
) (
  input  logic [CODE_W-1:0] code,
  output line_state_e       state,
  output logic              legal
);
  always_comb begin
    legal = 1'b1;
    case (code)
      CODE_W'(5'h0F): state = LS_COH_SHARED;
      CODE_W'(5'h13): state = LS_NC_EX_CLEAN;
      CODE_W'(5'h19): state = LS_NC_EX_DIRTY;
      CODE_W'(5'h16): state = LS_CO_EX_CLEAN;
      CODE_W'(5'h1C): state = LS_CO_EX_DIRTY;
      CODE_W'(5'h00): begin state = LS_INVALID; legal = 1'b0; end
      default:        begin state = LS_ILLEGAL; legal = 1'b0; end
    endcase
  end
endmodule

// File: rtl/dctag_parity_check.sv
module dctag_parity_check #(
  parameter int FIELD_W = 14
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               chk,
  output logic               mismatch
);
  always_comb mismatch = (^field) ^ chk;
endmodule

// File: rtl/dctag_lru_unpack.sv
module dctag_lru_unpack
  import dctag_pkg::*;
#(
  parameter int N_WAYS = WAYS,
  parameter int W_BITS = WAY_W
) (
  input  logic [N_WAYS*W_BITS-1:0] packed_order,
  output logic [W_BITS-1:0]        way_at [N_WAYS]
);
  for (genvar g = 0; g < N_WAYS; g++) begin : g_slot
    assign way_at[g] = packed_order[g*W_BITS +: W_BITS];
  end
endmodule

// File: rtl/dctag_checker.sv
module dctag_checker
  import dctag_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_strobe,
  input  logic [TAG_HI_W-1:0] tag_hi,
  input  logic [TAG_LO_W-1:0] tag_lo,
  input  logic [IDX_W-1:0]    line_idx,
  output logic                out_valid,
  output logic [2:0]          out_state,
  output logic                out_state_err,
  output logic                out_addr_err,
  output logic [PA_W-1:0]     out_paddr,
  output logic [LRU_W-1:0]    out_lru_order,
  output logic [1:0]          out_bank,
  output logic [5:0]          out_set
);
  localparam int PT1_W = PT1_HI - PT1_LO + 1;
  localparam int PT0_W = PT0_HI - PT0_LO + 1;

  line_state_e st_dec;
  logic        st_legal;
  logic        p1_bad, p0_bad;
  logic [WAY_W-1:0] ways [WAYS];
  logic [LRU_W-1:0] lru_repack;

  dctag_state_decode #(.CODE_W(ST_W)) u_dec (
    .code  (tag_hi[ST_LSB +: ST_W]),
    .state (st_dec),
    .legal (st_legal)
  );

  dctag_parity_check #(.FIELD_W(PT1_W)) u_par1 (
    .field    (tag_lo[PT1_HI:PT1_LO]),
    .chk      (tag_lo[PT1_CHK]),
    .mismatch (p1_bad)
  );

  dctag_parity_check #(.FIELD_W(PT0_W)) u_par0 (
    .field    (tag_lo[PT0_HI:PT0_LO]),
    .chk      (tag_lo[PT0_CHK]),
    .mismatch (p0_bad)
  );

  dctag_lru_unpack #(.N_WAYS(WAYS), .W_BITS(WAY_W)) u_lru (
    .packed_order (tag_hi[LRU_LSB +: LRU_W]),
    .way_at       (ways)
  );

  for (genvar g = 0; g < WAYS; g++) begin : g_repack
    assign lru_repack[g*WAY_W +: WAY_W] = ways[g];
  end

  logic unused_bits;
  assign unused_bits = ^{tag_hi[TAG_HI_W-1:ST_LSB+ST_W], tag_hi[ST_LSB-1:LRU_LSB+LRU_W],
                         tag_hi[LRU_LSB-1:0], tag_lo[TAG_LO_W-1:PA_W], tag_lo[9:0], tag_lo[12]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_state     <= 3'd0;
      out_state_err <= 1'b0;
      out_addr_err  <= 1'b0;
      out_paddr     <= '0;
      out_lru_order <= '0;
      out_bank      <= '0;
      out_set       <= '0;
    end else begin
      out_valid <= in_strobe;
      if (in_strobe) begin
        out_state     <= st_dec;
        out_state_err <= !st_legal;
        out_addr_err  <= st_legal && (p1_bad || p0_bad);
        out_paddr     <= {tag_lo[PA_W-1:IDX_W], line_idx};
        out_lru_order <= lru_repack;
        out_bank      <= {line_idx[12], line_idx[5]};
        out_set       <= line_idx[11:6];
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_strobe |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) !in_strobe |=> !out_valid); // R1
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) out_state_err |-> !out_addr_err); // R5
  AST_ERR_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_state_err == (out_state == 3'd0 || out_state == 3'd7))); // R3
  AST_PADDR_LOW: assert property (@(posedge clk) disable iff (rst)
    in_strobe |=> out_paddr[IDX_W-1:0] == $past(line_idx)); // R6
  AST_BANK_SET: assert property (@(posedge clk) disable iff (rst)
    in_strobe |=> {out_bank[1], out_set, out_bank[0]} == $past(line_idx[12:5])); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_strobe |=> $stable(out_paddr) && $stable(out_state) && $stable(out_lru_order)); // R9
endmodule

// File: tb/sim_dctag_checker.sv
module sim_dctag_checker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_strobe;
  logic [31:0] tag_hi;
  logic [63:0] tag_lo;
  logic [12:0] line_idx;
  logic        out_valid, out_state_err, out_addr_err;
  logic [2:0]  out_state;
  logic [39:0] out_paddr;
  logic [7:0]  out_lru_order;
  logic [1:0]  out_bank;
  logic [5:0]  out_set;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dctag_checker u0 (
    .clk(clk), .rst(rst), .in_strobe(in_strobe), .tag_hi(tag_hi), .tag_lo(tag_lo),
    .line_idx(line_idx), .out_valid(out_valid), .out_state(out_state),
    .out_state_err(out_state_err), .out_addr_err(out_addr_err), .out_paddr(out_paddr),
    .out_lru_order(out_lru_order), .out_bank(out_bank), .out_set(out_set)
  );

  function automatic logic [2:0] exp_state(input logic [4:0] c);
    case (c)
      5'h0F: return 3'd1;
      5'h13: return 3'd2;
      5'h19: return 3'd3;
      5'h16: return 3'd4;
      5'h1C: return 3'd5;
      5'h00: return 3'd0;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic exp_addr_err(input logic [4:0] c, input logic [63:0] lo);
    logic legal;
    legal = (exp_state(c) != 3'd0) && (exp_state(c) != 3'd7);
    return legal && ((lo[11] != ^lo[39:26]) || (lo[10] != ^lo[25:13]));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_tag(input logic [31:0] hi, input logic [63:0] lo, input logic [12:0] idx);
    logic [4:0] c;
    c = hi[29:25];
    tag_hi = hi; tag_lo = lo; line_idx = idx; in_strobe = 1'b1;
    @(negedge clk);
    in_strobe = 1'b0;
    chk("R1 valid", out_valid, 1);
    chk("R2 state", out_state, exp_state(c));
    chk("R3 state_err", out_state_err, (exp_state(c) == 3'd0 || exp_state(c) == 3'd7));
    chk("R4 addr_err", out_addr_err, exp_addr_err(c, lo));
    chk("R6 paddr", out_paddr, {lo[39:13], idx});
    chk("R7 lru", out_lru_order, hi[21:14]);
    chk("R8 bank", out_bank, {idx[12], idx[5]});
    chk("R8 set", out_set, idx[11:6]);
  endtask

  function automatic logic [63:0] fix_par(input logic [63:0] lo);
    logic [63:0] r;
    r = lo;
    r[11] = ^lo[39:26];
    r[10] = ^lo[25:13];
    return r;
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [4:0] legal_codes [5] = '{5'h0F, 5'h13, 5'h19, 5'h16, 5'h1C};
    logic [31:0] hi;
    logic [63:0] lo;
    logic [2:0]  s_state;
    logic [39:0] s_paddr;
    void'($urandom(32'd4711));
    rst = 1'b1; in_strobe = 1'b0; tag_hi = '0; tag_lo = '0; line_idx = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset valid", out_valid, 0);
    chk("R9 reset state_err", out_state_err, 0);
    chk("R9 reset addr_err", out_addr_err, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2: each legal code with good parity
    for (int i = 0; i < 5; i++) begin
      hi = $urandom; hi[29:25] = legal_codes[i];
      lo = fix_par({$urandom, $urandom});
      run_tag(hi, lo, 13'($urandom));
    end
    // R3: invalid code and an illegal code
    hi = 32'h0; run_tag(hi, 64'h0, 13'h1FFF);
    hi = 32'h0; hi[29:25] = 5'h1F; run_tag(hi, 64'hFF_FFFF_FFFF, 13'h0020);
    // R4: flip each parity bit on a legal line
    hi = 32'h0; hi[29:25] = 5'h16;
    lo = fix_par(64'h00AB_CDEF_1234_5678); lo[11] = ~lo[11]; run_tag(hi, lo, 13'h1000);
    lo = fix_par(64'h00AB_CDEF_1234_5678); lo[10] = ~lo[10]; run_tag(hi, lo, 13'h0FC0);
    // R5: bad parity on an illegal code gives no address error
    hi[29:25] = 5'h01; lo[11] = ~lo[11]; run_tag(hi, lo, 13'h0040);
    // R7: distinct LRU order
    hi = 32'h0; hi[29:25] = 5'h0F; hi[21:14] = 8'b00_01_10_11;
    run_tag(hi, fix_par(64'h0), 13'h0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      hi = $urandom;
      if ($urandom % 2) hi[29:25] = legal_codes[$urandom % 5];
      lo = {$urandom, $urandom};
      if ($urandom % 2) lo = fix_par(lo);
      run_tag(hi, lo, 13'($urandom));
      if ($urandom % 4 == 0) begin
        // R1/R9: idle cycle holds results, no valid
        s_state = out_state; s_paddr = out_paddr;
        tag_hi = $urandom; tag_lo = {$urandom, $urandom}; line_idx = 13'($urandom);
        @(negedge clk);
        chk("R1 no valid", out_valid, 0);
        chk("R9 hold state", out_state, s_state);
        chk("R9 hold paddr", out_paddr, s_paddr);
      end
    end

    // R9: reset clears flags after an erroring tag
    hi = 32'h0; hi[29:25] = 5'h02; run_tag(hi, 64'h0, 13'h0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R9 reset state_err again", out_state_err, 0);
    chk("R9 reset valid again", out_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule